// File: doc/BRIEF.md
# Halfband Interpolate-by-Two FIR

This block doubles the sample rate of a signed integer sample stream with a halfband low-pass filter. Each sample accepted on the input handshake yields two output samples. The first comes from the even-indexed polyphase, which holds the symmetric outer taps. The second comes from the odd polyphase, which holds only the center tap. Outputs leave through a valid/ready handshake in that fixed order. No new input is taken until both outputs of the current pair have been accepted.

Software never supplies the full tap list. It writes a compressed set: the N distinct non-zero outer coefficients, followed by the center coefficient at index N. Here N = (TAPS+1)/4, and a TAPS value that does not give a whole N fails elaboration. The block rebuilds the full filter itself: every other tap is zero and the outer taps mirror about the center. Writes go to a shadow bank, and the bank is applied only on a frame boundary of FRAME_LEN input samples. The center tap can also be used in a second way, as a left-shift amount for the delayed sample instead of as a multiplier.

Both polyphase results are wide accumulations. A separate output stage shifts them down by SHIFT bits, rounds them by a selectable rule and saturates them by a selectable rule to the sample width.

Top module: `halfband_interp2`

## Requirements
- R1: After reset, inReady is 1 and outValid is 0, and the delay line holds zeros, so the outputs of the first samples after reset depend only on samples accepted since reset.
- R2: Coefficient writes use index 0..N-1 for the outer taps c0..c(N-1) and index N for the center tap. A write with an index above N changes nothing.
- R3: With outer coefficients c0..c(N-1) and center cc, the output stream equals the input upsampled by two with zeros and filtered by the TAPS-long filter c0,0,c1,0,…,c(N-1),cc,c(N-1),0,…,0,c0, before scaling.
- R4: Every accepted input produces exactly two outputs, the outer-tap polyphase result first and the center-tap result second. inReady stays low until the second output has been accepted, so a frame of V inputs gives 2V outputs.
- R5: While outValid is 1 and outReady is 0, outValid and outData hold their values.
- R6: The first output of a pair is valid in the second cycle after the input handshake edge, and outValid is 0 in the cycle between.
- R7: When ctShiftMode is 1, the center result is the delayed sample shifted left by the center coefficient. Negative values are treated as 0 and values above 47 as 47. The outer-tap result is unchanged.
- R8: Coefficient writes and ctShiftMode take effect only from the first sample of the next frame. Frames are FRAME_LEN accepted inputs counted from reset.
- R9: Results are divided by 2^SHIFT with rounding set by rndMode: 0 rounds down toward minus infinity, 1 rounds halves up, 2 rounds halves away from zero, 3 rounds halves to even.
- R10: Saturation is set by satMode: 0 keeps the low DATA_W bits, 1 or 3 clamps to [-2^(DATA_W-1), 2^(DATA_W-1)-1], and 2 clamps to [-(2^(DATA_W-1)-1), 2^(DATA_W-1)-1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample offered |
| inReady | output | 1 | Block can accept an input sample |
| inData | input | DATA_W | Signed input sample |
| outValid | output | 1 | Output sample available |
| outReady | input | 1 | Consumer accepts the output sample |
| outData | output | DATA_W | Signed scaled output sample |
| coefWrEn | input | 1 | Write strobe for the shadow coefficient bank |
| coefWrIdx | input | IDX_W | Compressed coefficient index (center at N) |
| coefWrData | input | COEF_W | Signed coefficient value |
| ctShiftMode | input | 1 | Use the center coefficient as a shift amount |
| rndMode | input | 2 | Rounding rule for the downshift |
| satMode | input | 2 | Saturation rule for the output |

## Verification
The bench drives a unit impulse through freshly loaded compressed coefficients. A design that indexes the mirror wrongly, or puts the center tap at the wrong delay, shows a skewed or asymmetric impulse response. Accumulations that land exactly on a half step are fed under each rounding rule and on both signs, so a swapped tie rule gives a result off by one. Full-scale inputs run under each saturation rule, and a wrong limit shows up as wrapped or off-by-one extremes. Center-shift amounts of -2 and 60 check the clamping, since an unclamped 60 overflows the accumulator and flips the saturated sign. Coefficients and the shift mode are rewritten in the middle of a frame to catch a bank that switches early. Random backpressure checks that pairs are neither dropped nor reordered.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  // Strobes sent from the sequencer to the datapath each cycle
  typedef struct packed {
    logic shiftIn;   // input sample accepted: advance delay line
    logic calc;      // capture both polyphase accumulations
    logic selCt;     // present center-tap result instead of outer-tap result
    logic swapCoef;  // frame boundary: shadow bank becomes active
  } hbiStrobe_t;

  typedef enum logic [1:0] {
    RND_FLOOR     = 2'd0,
    RND_HALF_UP   = 2'd1,
    RND_HALF_AWAY = 2'd2,
    RND_HALF_EVEN = 2'd3
  } rndMode_e;

  typedef enum logic [1:0] {
    SAT_WRAP  = 2'd0,
    SAT_CLAMP = 2'd1,
    SAT_SYM   = 2'd2,
    SAT_CLAMP2 = 2'd3
  } satMode_e;

  localparam int MAX_UPSHIFT = 47;

endpackage

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
  import hbi_pkg::*;
#(
  parameter int FRAME_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output hbiStrobe_t strobe
);

  localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_OUT_EVEN, S_OUT_CT} state_e;

  state_e state, stateNext;
  logic [CNT_W-1:0] frameCnt;
  logic accept;

  assign accept = inValid && (state == S_IDLE);

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:     if (inValid)  stateNext = S_CALC;
      S_CALC:                   stateNext = S_OUT_EVEN;
      S_OUT_EVEN: if (outReady) stateNext = S_OUT_CT;
      S_OUT_CT:   if (outReady) stateNext = S_IDLE;
      default:                  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      frameCnt <= '0;
    end else begin
      state <= stateNext;
      if (accept) frameCnt <= (frameCnt == CNT_LAST) ? '0 : frameCnt + 1'b1;
    end
  end

  always_comb begin
    inReady         = (state == S_IDLE);
    outValid        = (state == S_OUT_EVEN) || (state == S_OUT_CT);
    strobe.shiftIn  = accept;
    strobe.calc     = (state == S_CALC);
    strobe.selCt    = (state == S_OUT_CT);
    strobe.swapCoef = (state == S_IDLE) && (frameCnt == '0);
  end

endmodule

// File: rtl/hbi_datapath.sv
module hbi_datapath
  import hbi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int TAPS   = 7,
  parameter int ACC_W  = 64,
  parameter int IDX_W  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  hbiStrobe_t               strobe,
  input  logic signed [DATA_W-1:0] inData,
  input  logic                     coefWrEn,
  input  logic [IDX_W-1:0]         coefWrIdx,
  input  logic signed [COEF_W-1:0] coefWrData,
  input  logic                     ctShiftMode,
  output logic signed [ACC_W-1:0]  accSel
);

  localparam int N      = (TAPS + 1) / 4;
  localparam int DEPTH  = 2 * N;
  localparam int PRE_W  = DATA_W + 1;
  localparam bit UPSHIFT_OK = (COEF_W == 16);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N);

  logic signed [DATA_W-1:0] delayLine [DEPTH];
  logic signed [COEF_W-1:0] shadowCoef [N+1];
  logic signed [COEF_W-1:0] activeCoef [N+1];
  logic                     activeShift;
  logic signed [ACC_W-1:0]  evenSum, ctTerm;
  logic signed [ACC_W-1:0]  accEven, accCt;

  // Shadow bank: written at any time, indices above N are dropped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i <= N; i++) shadowCoef[i] <= '0;
    end else if (coefWrEn && (coefWrIdx <= LAST_IDX)) begin
      shadowCoef[coefWrIdx] <= coefWrData;
    end
  end

  // Active bank and shift mode only change on a frame boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i <= N; i++) activeCoef[i] <= '0;
      activeShift <= 1'b0;
    end else if (strobe.swapCoef) begin
      activeCoef  <= shadowCoef;
      activeShift <= UPSHIFT_OK && ctShiftMode;
    end
  end

  // Delay line, newest sample at position 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) delayLine[i] <= '0;
    end else if (strobe.shiftIn) begin
      delayLine[0] <= inData;
      for (int i = 1; i < DEPTH; i++) delayLine[i] <= delayLine[i-1];
    end
  end

  // Outer-tap polyphase: fold mirrored pairs, then one multiply per pair
  always_comb begin
    logic signed [PRE_W-1:0] folded;
    evenSum = '0;
    for (int j = 0; j < N; j++) begin
      folded  = PRE_W'(delayLine[j]) + PRE_W'(delayLine[DEPTH-1-j]);
      evenSum = evenSum + (ACC_W'(folded) * ACC_W'(activeCoef[j]));
    end
  end

  // Center-tap polyphase: single multiply, or a shift when enabled
  generate
    if (UPSHIFT_OK) begin : gCtShift
      localparam logic signed [COEF_W-1:0] AMT_MAX = COEF_W'(MAX_UPSHIFT);
      logic [5:0] shiftAmt;
      always_comb begin
        if (activeCoef[N][COEF_W-1])       shiftAmt = 6'd0;
        else if (activeCoef[N] > AMT_MAX)  shiftAmt = 6'(MAX_UPSHIFT);
        else                               shiftAmt = activeCoef[N][5:0];
        if (activeShift) ctTerm = ACC_W'(delayLine[N-1]) <<< shiftAmt;
        else             ctTerm = ACC_W'(delayLine[N-1]) * ACC_W'(activeCoef[N]);
      end
    end else begin : gCtMult
      always_comb ctTerm = ACC_W'(delayLine[N-1]) * ACC_W'(activeCoef[N]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accEven <= '0;
      accCt   <= '0;
    end else if (strobe.calc) begin
      accEven <= evenSum;
      accCt   <= ctTerm;
    end
  end

  assign accSel = strobe.selCt ? accCt : accEven;

endmodule

// File: rtl/hbi_scaler.sv
module hbi_scaler
  import hbi_pkg::*;
#(
  parameter int ACC_W  = 64,
  parameter int DATA_W = 16,
  parameter int SHIFT  = 2
) (
  input  logic signed [ACC_W-1:0]  accIn,
  input  logic [1:0]               rndMode,
  input  logic [1:0]               satMode,
  output logic signed [DATA_W-1:0] outData
);

  localparam int EXT_W = ACC_W + 1;
  localparam logic signed [EXT_W-1:0] POS_LIM =
    {{(EXT_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] NEG_LIM = ~POS_LIM;
  localparam logic signed [EXT_W-1:0] NEG_SYM = NEG_LIM + 1'b1;

  logic signed [EXT_W-1:0] rounded;

  generate
    if (SHIFT == 0) begin : gNoShift
      assign rounded = EXT_W'(accIn);
    end else begin : gShift
      localparam logic [SHIFT-1:0] HALF = SHIFT'(1) << (SHIFT - 1);
      logic signed [ACC_W-1:0] floorVal;
      logic [SHIFT-1:0]        frac;
      logic                    bump;
      always_comb begin
        floorVal = accIn >>> SHIFT;
        frac     = accIn[SHIFT-1:0];
        unique case (rndMode_e'(rndMode))
          RND_FLOOR:     bump = 1'b0;
          RND_HALF_UP:   bump = (frac >= HALF);
          RND_HALF_AWAY: bump = accIn[ACC_W-1] ? (frac > HALF) : (frac >= HALF);
          RND_HALF_EVEN: bump = (frac > HALF) || ((frac == HALF) && floorVal[0]);
          default:       bump = 1'b0;
        endcase
        rounded = EXT_W'(floorVal) + EXT_W'(bump);
      end
    end
  endgenerate

  always_comb begin
    unique case (satMode_e'(satMode))
      SAT_WRAP: outData = rounded[DATA_W-1:0];
      SAT_SYM: begin
        if (rounded > POS_LIM)      outData = POS_LIM[DATA_W-1:0];
        else if (rounded < NEG_SYM) outData = NEG_SYM[DATA_W-1:0];
        else                        outData = rounded[DATA_W-1:0];
      end
      default: begin
        if (rounded > POS_LIM)      outData = POS_LIM[DATA_W-1:0];
        else if (rounded < NEG_LIM) outData = NEG_LIM[DATA_W-1:0];
        else                        outData = rounded[DATA_W-1:0];
      end
    endcase
  end

endmodule

// File: rtl/halfband_interp2.sv
module halfband_interp2
  import hbi_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int TAPS      = 7,
  parameter int FRAME_LEN = 4,
  parameter int SHIFT     = 2,
  localparam int N        = (TAPS + 1) / 4,
  localparam int IDX_W    = (N + 1 > 2) ? $clog2(N + 1) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic signed [DATA_W-1:0] outData,
  input  logic                     coefWrEn,
  input  logic [IDX_W-1:0]         coefWrIdx,
  input  logic signed [COEF_W-1:0] coefWrData,
  input  logic                     ctShiftMode,
  input  logic [1:0]               rndMode,
  input  logic [1:0]               satMode
);

  localparam bit UPSHIFT_OK = (COEF_W == 16);
  localparam int SUM_W = DATA_W + 1 + COEF_W + ((N > 1) ? $clog2(N) : 0);
  localparam int UP_W  = DATA_W + MAX_UPSHIFT + 1;
  localparam int ACC_W = (UPSHIFT_OK && (UP_W > SUM_W)) ? UP_W : SUM_W;

  generate
    if (((TAPS + 1) % 4 != 0) || (TAPS < 3)) begin : gBadTaps
      $error("TAPS must satisfy (TAPS+1)/4 = positive integer");
    end
  endgenerate

  hbiStrobe_t strobe;
  logic signed [ACC_W-1:0] accSel;

  hbi_ctrl #(.FRAME_LEN(FRAME_LEN)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  hbi_datapath #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .TAPS   (TAPS),
    .ACC_W  (ACC_W),
    .IDX_W  (IDX_W)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inData      (inData),
    .coefWrEn    (coefWrEn),
    .coefWrIdx   (coefWrIdx),
    .coefWrData  (coefWrData),
    .ctShiftMode (ctShiftMode),
    .accSel      (accSel)
  );

  hbi_scaler #(
    .ACC_W  (ACC_W),
    .DATA_W (DATA_W),
    .SHIFT  (SHIFT)
  ) uScale (
    .accIn   (accSel),
    .rndMode (rndMode),
    .satMode (satMode),
    .outData (outData)
  );

endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData
);

  // Outputs still owed for accepted inputs
  logic [1:0] owed;

  always_ff @(posedge clk) begin
    if (!rstN) owed <= '0;
    else if (inValid && inReady) owed <= owed + 2'd2 - {1'b0, outValid && outReady};
    else if (outValid && outReady) owed <= owed - 2'd1;
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (inReady && !outValid));

  p_owed_bounded_r4: assert property (@(posedge clk) disable iff (!rstN)
    owed <= 2'd2);

  p_no_accept_while_owed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (owed != 2'd0) |-> !inReady);

  p_ready_after_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    (owed == 2'd1 && outValid && outReady) |=> inReady);

  p_hold_output_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  p_first_out_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (!outValid ##1 outValid));

endmodule

bind halfband_interp2 hbi_checker #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/halfband_interp2_test.sv
module halfband_interp2_test;

  localparam int DATA_W = 16;
  localparam int COEF_W = 16;
  localparam int TAPS   = 7;
  localparam int FRAME  = 4;
  localparam int SHIFT  = 2;
  localparam int N      = (TAPS + 1) / 4;
  localparam int DEPTH  = 2 * N;
  localparam int IDX_W  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic signed [DATA_W-1:0] inData = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic signed [DATA_W-1:0] outData;
  logic coefWrEn = 1'b0;
  logic [IDX_W-1:0] coefWrIdx = '0;
  logic signed [COEF_W-1:0] coefWrData = '0;
  logic ctShiftMode = 1'b0;
  logic [1:0] rndMode = 2'd0;
  logic [1:0] satMode = 2'd1;

  always #2 clk = ~clk;  // 250 MHz

  halfband_interp2 #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .FRAME_LEN(FRAME), .SHIFT(SHIFT)
  ) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .coefWrEn(coefWrEn), .coefWrIdx(coefWrIdx), .coefWrData(coefWrData),
    .ctShiftMode(ctShiftMode), .rndMode(rndMode), .satMode(satMode)
  );

  typedef struct { longint val; string tag; } expItem_t;
  expItem_t expQ[$];

  int nChk = 0;
  int nBad = 0;
  int nIn  = 0;
  int nOut = 0;
  int readySel = 0;          // 0 always ready, 1 pseudo-random, 2 never
  logic [7:0] lfsr = 8'hA5;

  longint hist [DEPTH];
  longint shC [N+1];
  longint acC [N+1];
  bit     acShift = 1'b0;
  int     fcnt = 0;

  task automatic check(bit ok, string tag, longint got, longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic longint scaleOut(longint v);
    longint q, f, h;
    q = v >>> SHIFT;
    f = v - (q <<< SHIFT);
    h = 64'sd1 <<< (SHIFT - 1);
    case (rndMode)
      2'd1: if (f >= h) q++;
      2'd2: if ((v >= 0) ? (f >= h) : (f > h)) q++;
      2'd3: if ((f > h) || ((f == h) && q[0])) q++;
      default: ;
    endcase
    case (satMode)
      2'd0: q = longint'($signed(q[15:0]));
      2'd2: begin if (q > 32767) q = 32767; if (q < -32767) q = -32767; end
      default: begin if (q > 32767) q = 32767; if (q < -32768) q = -32768; end
    endcase
    return q;
  endfunction

  // Driver: offer one sample, update the reference model on acceptance
  task automatic sendSample(longint x, string tag);
    longint y0, y1, amt;
    inValid = 1'b1;
    inData  = DATA_W'(x);
    do @(negedge clk); while (!inReady);
    @(posedge clk);
    #1 inValid = 1'b0;
    if (fcnt == 0) begin
      acC = shC;
      acShift = ctShiftMode;
    end
    fcnt = (fcnt + 1) % FRAME;
    for (int i = DEPTH - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    y0 = 0;
    for (int j = 0; j < N; j++) y0 += acC[j] * (hist[j] + hist[DEPTH-1-j]);
    if (acShift) begin
      amt = acC[N];
      if (amt < 0) amt = 0;
      if (amt > 47) amt = 47;
      y1 = hist[N-1] <<< amt;
    end else begin
      y1 = acC[N] * hist[N-1];
    end
    expQ.push_back('{scaleOut(y0), tag});
    expQ.push_back('{scaleOut(y1), tag});
    nIn++;
  endtask

  task automatic coefWrite(int idx, longint v);
    @(posedge clk);
    #1;
    coefWrEn = 1'b1; coefWrIdx = IDX_W'(idx); coefWrData = COEF_W'(v);
    @(posedge clk);
    #1 coefWrEn = 1'b0;
    if (idx <= N) shC[idx] = v;
  endtask

  task automatic loadSet(longint c0, longint c1, longint cc);
    coefWrite(0, c0);
    coefWrite(1, c1);
    coefWrite(N, cc);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  // Monitor: compare each accepted output against the queue head
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      nOut++;
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected output", longint'(outData), 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(longint'(outData) == e.val, e.tag, longint'(outData), e.val);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (readySel)
      0: outReady = 1'b1;
      1: outReady = lfsr[0];
      default: outReady = 1'b0;
    endcase
  end

  task automatic runTests();
    logic [DATA_W-1:0] held;
    for (int i = 0; i < DEPTH; i++) hist[i] = 0;
    for (int i = 0; i <= N; i++) begin shC[i] = 0; acC[i] = 0; end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 inReady after reset", longint'(inReady), 1);
    check(outValid == 1'b0, "R1 outValid after reset", longint'(outValid), 0);

    // R1/R3: impulse through compressed set 1,2,5 (scaled by 4 for SHIFT)
    loadSet(4, 8, 20);
    sendSample(1000, "R1 zero history");
    sendSample(0, "R3 impulse");
    sendSample(0, "R3 impulse");
    sendSample(0, "R3 impulse");
    drain();

    // R9: each rounding rule with exact ties of both signs
    loadSet(1, 1, 1);
    for (int m = 0; m < 4; m++) begin
      rndMode = 2'(m);
      sendSample(2, "R9 rounding");  sendSample(-2, "R9 rounding");
      sendSample(1, "R9 rounding");  sendSample(-5, "R9 rounding");
      sendSample(6, "R9 rounding");  sendSample(-6, "R9 rounding");
      sendSample(3, "R9 rounding");  sendSample(-3, "R9 rounding");
      drain();
    end
    rndMode = 2'd0;

    // R10: full-scale inputs under each saturation rule
    loadSet(32767, 32767, 32767);
    for (int m = 0; m < 3; m++) begin
      satMode = 2'(m);
      sendSample(32767, "R10 saturation");  sendSample(32767, "R10 saturation");
      sendSample(-32768, "R10 saturation"); sendSample(-32768, "R10 saturation");
      drain();
    end
    satMode = 2'd1;

    // R7: center coefficient used as shift amount, with clamping
    ctShiftMode = 1'b1;
    loadSet(4, 8, 3);
    sendSample(100, "R7 upshift");  sendSample(-7, "R7 upshift");
    sendSample(9, "R7 upshift");    sendSample(0, "R7 upshift");
    coefWrite(N, 60);
    sendSample(8, "R7 clamp high"); sendSample(8, "R7 clamp high");
    sendSample(0, "R7 clamp high"); sendSample(0, "R7 clamp high");
    coefWrite(N, -2);
    sendSample(40, "R7 clamp low"); sendSample(-40, "R7 clamp low");
    sendSample(12, "R7 clamp low"); sendSample(0, "R7 clamp low");
    drain();

    // R8: rewrite coefficients and shift mode mid-frame
    sendSample(50, "R8 frame boundary");
    sendSample(-30, "R8 frame boundary");
    ctShiftMode = 1'b0;
    loadSet(12, -4, 8);
    sendSample(70, "R8 frame boundary");
    sendSample(20, "R8 frame boundary");
    sendSample(-90, "R8 frame boundary");
    sendSample(15, "R8 frame boundary");
    // R2: index above N is dropped
    coefWrite(3, 999);
    sendSample(33, "R2 out-of-range write");
    sendSample(-1, "R2 out-of-range write");
    drain();

    // R5/R6: output held under backpressure, first output timing
    readySel = 2;
    sendSample(400, "R5 held output");
    @(negedge clk);
    check(outValid == 1'b0, "R6 gap cycle", longint'(outValid), 0);
    @(negedge clk);
    check(outValid == 1'b1, "R6 first output", longint'(outValid), 1);
    held = outData;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(outValid == 1'b1, "R5 valid held", longint'(outValid), 1);
      check(outData == held, "R5 data held", longint'(outData), longint'($signed(held)));
      check(inReady == 1'b0, "R4 no accept while owed", longint'(inReady), 0);
    end
    readySel = 0;
    sendSample(-250, "R4 filler");
    drain();

    // R4: random backpressure over several frames
    readySel = 1;
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < FRAME; s++)
        sendSample(longint'((f * 977 + s * 313) % 4001) - 2000, "R4 backpressure");
    readySel = 0;
    drain();
    check(nOut == 2 * nIn, "R4 two outputs per input", nOut, 2 * nIn);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule